// File: doc/BRIEF.md
# One-Bit Transmit Retiming Buffer

This block sits between a host and a frequency-shift-keying modulator that sends data at 1200 bit/s. The host does not need a UART. It presents each transmit bit on a data pin and gives a loosely timed strobe. The buffer then hands the bits to the modulator on an exact bit grid. The grid is an internal bit tick, derived by dividing the master clock (3.579545 MHz by default).

There are two one-bit registers in series:

- **Capture register.** It takes the data pin when the strobe rises.
- **Output register.** It takes the capture register on every bit tick.

At each tick the strobe level is also recorded, and it selects the mode:

- **Strobe low (retimed mode).** The modulator gets the output register, and a ready flag asks the host for the next bit.
- **Strobe high (bypass mode).** The modulator follows the data pin directly.

A host that never wants retiming simply holds the strobe high.

The ready flag has two outputs: a logic level and an active-low drive enable, which suits an open-drain pad. A sleep input holds the divider, both registers and the ready flag in their reset state.

Top module: `bit_retime_buffer`

## Requirements
- R1: After reset, rdy_n and rdy_oe_n are 1 (ready released), both bit registers hold 0, and the block is in bypass mode.
- R2: When the strobe was high at the most recent bit tick (or no tick has occurred since reset or sleep), mod_bit follows data_in with a latency of exactly SYNC_STAGES clock cycles.
- R3: A low-to-high transition of the synchronised strobe copies the synchronised data pin into the capture register. Data changes without a strobe rising edge leave the capture register unchanged.
- R4: Bit ticks occur exactly every TICK_DIV clock cycles while not sleeping. The default of 2983 gives about 1199.98 bit/s, which lies inside 1194 to 1206 bit/s.
- R5: At each bit tick the output register loads the capture register. When the strobe was low at that tick, mod_bit equals the output register and stays constant until the next tick, whatever data_in does.
- R6: A bit tick that samples the synchronised strobe low asserts ready: rdy_n goes to 0 one cycle after the tick.
- R7: A high level on the synchronised strobe releases ready (rdy_n = 1) on the following cycle, and keeps it released while the strobe stays high.
- R8: While sleep is 1, no ticks occur, ready is released one cycle after sleep rises, and both bit registers return to 0.
- R9: rdy_oe_n equals rdy_n at all times, so the pad is pulled low exactly while ready is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Zero-power hold: divider and registers held in reset |
| strobe_in | input | 1 | Host strobe: rising edge loads a bit, level selects bypass at each tick |
| data_in | input | 1 | Host transmit data pin |
| mod_bit | output | 1 | Bit delivered to the modulator |
| rdy_n | output | 1 | Ready level, active low (1 = released) |
| rdy_oe_n | output | 1 | Active-low pad drive enable for the open-drain ready output |

## Verification
The bound checker watches every cycle for the following:

- the exact tick spacing;
- ready being set by a tick that sees a low strobe, and cleared by a high strobe;
- sleep forcing ready released;
- the retimed output holding still between ticks;
- the bypass selection taking effect after a tick that sees a high strobe.

Some behaviours show up only in the bench's scenarios, because they depend on what the host loads:

- that the bit captured on a strobe rising edge is the one that appears at the next tick;
- that data changes without an edge are ignored;
- the exact synchroniser latency in bypass;
- that the registers are cleared by sleep.

// File: rtl/bitrt_pkg.sv
package bitrt_pkg;

    // Register state of the retiming core
    typedef struct packed {
        logic cap_bit;      // capture register, loaded on strobe rise
        logic out_bit;      // output register, loaded on bit tick
        logic bypass;       // strobe level seen at the last tick
        logic ready;        // 1 = host asked for the next bit
        logic strobe_prev;  // synchronised strobe, one cycle late
    } core_state_t;

    localparam core_state_t CORE_RESET = '{
        cap_bit:     1'b0,
        out_bit:     1'b0,
        bypass:      1'b1,
        ready:       1'b0,
        strobe_prev: 1'b1
    };

endpackage

// File: rtl/bitrt_sync.sv
module bitrt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bitrt_tick.sv
module bitrt_tick #(
    parameter int TICK_DIV = 2983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (hold)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = !hold && (cnt_q == LAST);
endmodule

// File: rtl/bitrt_core.sv
module bitrt_core
    import bitrt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic strobe_s,
    input  logic data_s,
    output logic mod_bit,
    output logic ready,
    output logic bypass
);
    core_state_t st_d, st_q;
    logic        strobe_rise;

    always_comb begin
        st_d        = st_q;
        strobe_rise = strobe_s && !st_q.strobe_prev;
        st_d.strobe_prev = strobe_s;

        if (hold) begin
            st_d             = CORE_RESET;
            st_d.strobe_prev = strobe_s;
        end else begin
            if (strobe_rise)
                st_d.cap_bit = data_s;
            if (tick) begin
                st_d.out_bit = st_q.cap_bit;
                st_d.bypass  = strobe_s;
            end
            if (strobe_s)
                st_d.ready = 1'b0;
            else if (tick)
                st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_RESET;
        else        st_q <= st_d;
    end

    assign mod_bit = st_q.bypass ? data_s : st_q.out_bit;
    assign ready   = st_q.ready;
    assign bypass  = st_q.bypass;
endmodule

// File: rtl/bit_retime_buffer.sv
module bit_retime_buffer #(
    parameter int TICK_DIV    = 2983,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic strobe_in,
    input  logic data_in,
    output logic mod_bit,
    output logic rdy_n,
    output logic rdy_oe_n
);
    localparam int   NPINS         = 2;
    localparam logic [NPINS-1:0] PIN_RST = 2'b01; // strobe idles high

    logic [NPINS-1:0] pins_raw, pins_s;
    logic strobe_s, data_s, tick, ready, core_bypass;

    assign pins_raw = {data_in, strobe_in};

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_sync
            bitrt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[p])) u_sync (
                .clk(clk), .rst_n(rst_n), .async_i(pins_raw[p]), .sync_o(pins_s[p])
            );
        end
    endgenerate

    assign strobe_s = pins_s[0];
    assign data_s   = pins_s[1];

    bitrt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .hold(sleep), .tick_o(tick)
    );

    bitrt_core u_core (
        .clk(clk), .rst_n(rst_n), .hold(sleep), .tick(tick),
        .strobe_s(strobe_s), .data_s(data_s),
        .mod_bit(mod_bit), .ready(ready), .bypass(core_bypass)
    );

    assign rdy_n    = !ready;
    assign rdy_oe_n = !ready;
endmodule

// File: rtl/bit_retime_buffer_chk.sv
module bit_retime_buffer_chk #(
    parameter int TICK_DIV = 2983
) (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic tick,
    input logic strobe_s,
    input logic data_s,
    input logic bypass,
    input logic mod_bit,
    input logic rdy_n,
    input logic rdy_oe_n
);
    int unsigned since_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_tick <= 0;
        else if (sleep || tick)  since_tick <= 0;
        else                     since_tick <= since_tick + 1;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (since_tick == TICK_DIV - 1));

    // R8
    sleep_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !tick);

    // R8
    sleep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> rdy_n);

    // R6
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !strobe_s && !sleep) |=> !rdy_n);

    // R7
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_s |=> rdy_n);

    // R5
    retimed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !tick && !sleep) |=> $stable(mod_bit));

    // R2
    bypass_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && strobe_s) |=> (mod_bit == data_s));

    // R9
    pad_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe_n == rdy_n);
endmodule

bind bit_retime_buffer bit_retime_buffer_chk #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .tick(tick),
    .strobe_s(strobe_s), .data_s(data_s), .bypass(core_bypass),
    .mod_bit(mod_bit), .rdy_n(rdy_n), .rdy_oe_n(rdy_oe_n)
);

// File: tb/tb_bit_retime_buffer.sv
module tb_bit_retime_buffer;
    localparam int DIV  = 40;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep = 1'b0;
    logic strobe_in = 1'b1;
    logic data_in = 1'b0;
    logic mod_bit, rdy_n, rdy_oe_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_fall = -1;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    bit_retime_buffer #(.TICK_DIV(DIV), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .strobe_in(strobe_in),
        .data_in(data_in), .mod_bit(mod_bit), .rdy_n(rdy_n), .rdy_oe_n(rdy_oe_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // wait for ready to assert; returns 1 if seen
    task automatic wait_ready(input int limit, output bit seen);
        seen = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge clk);
            if (rdy_n == 1'b0) seen = 1;
        end
    endtask

    task automatic test_reset();
        nwait(1);
        check("R1 rdy_n", rdy_n, 1);
        check("R1 rdy_oe_n", rdy_oe_n, 1);
        rst_n = 1'b1;
        nwait(3);
        check("R1 bypass after reset", mod_bit, 0);
    endtask

    task automatic test_bypass();
        strobe_in = 1'b1;
        data_in = 1'b1;
        nwait(SYNC - 1);
        check("R2 before latency", mod_bit, 0);
        nwait(1);
        check("R2 at latency", mod_bit, 1);
        data_in = 1'b0;
        nwait(SYNC);
        check("R2 follows 0", mod_bit, 0);
        check("R7 strobe high keeps released", rdy_n, 1);
    endtask

    task automatic test_retime_entry();
        bit seen;
        strobe_in = 1'b0;
        data_in = 1'b0;
        wait_ready(2 * DIV + 4, seen);
        check("R6 ready asserted", seen, 1);
        last_fall = cyc;
        check("R5 first retimed bit from reset capture", mod_bit, 0);
        check("R9 pad enable", rdy_oe_n, 0);
    endtask

    task automatic load_bit(input logic b, input string tag);
        bit seen;
        int gap;
        data_in = b;
        nwait(3);
        strobe_in = 1'b1;
        nwait(4);
        check({"R7 release ", tag}, rdy_n, 1);
        check({"R9 pad off ", tag}, rdy_oe_n, 1);
        strobe_in = 1'b0;
        nwait(3);
        wait_ready(2 * DIV + 4, seen);
        check({"R6 ready ", tag}, seen, 1);
        check({"R3 R5 loaded ", tag}, mod_bit, b);
        gap = cyc - last_fall;
        check({"R4 tick grid ", tag}, gap % DIV, 0);
        last_fall = cyc;
        data_in = ~b;
        nwait(DIV / 2);
        check({"R5 held between ticks ", tag}, mod_bit, b);
    endtask

    task automatic test_no_edge();
        // data already toggled by load_bit, strobe stays low
        nwait(DIV + 5);
        check("R3 no edge keeps capture", mod_bit, 1);
        check("R6 ready stays asserted", rdy_n, 0);
    endtask

    task automatic test_sleep();
        bit seen;
        sleep = 1'b1;
        nwait(1);
        check("R8 ready released", rdy_n, 1);
        nwait(3 * DIV);
        check("R8 no tick while asleep", rdy_n, 1);
        sleep = 1'b0;
        wait_ready(DIV + 4, seen);
        check("R8 ready after wake", seen, 1);
        check("R8 registers cleared", mod_bit, 0);
    endtask

    task automatic test_back_to_bypass();
        strobe_in = 1'b1;
        nwait(DIV + 5);
        data_in = 1'b1;
        nwait(SYNC);
        check("R2 bypass restored 1", mod_bit, 1);
        data_in = 1'b0;
        nwait(SYNC);
        check("R2 bypass restored 0", mod_bit, 0);
    endtask

    initial begin
        test_reset();
        test_bypass();
        test_retime_entry();
        load_bit(1'b1, "one");
        test_no_edge();
        load_bit(1'b0, "zero");
        load_bit(1'b1, "one again");
        test_sleep();
        test_back_to_bypass();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule